// File: doc/BRIEF.md
# Tick-Synchronized Register Write Port

This block is the bus-facing register front end of a real-time-clock peripheral. The peripheral's control and alarm registers must only change on the slow timekeeping tick. A host write to one of these synchronized registers is captured into a single holding slot and flagged as pending. On the next slow tick the held value is committed and a sticky write-done status flag is set. While a write is held, any further synchronized write is dropped. Host software is expected to poll the pending flag, or wait for the write-done interrupt, before it issues the next write.

The interrupt status register is outside this scheme. Writes to it act in the same cycle, and each 1 clears the matching bit. The slow tick comes from an internal prescaler that divides the bus clock by `DIV` and is presented as a one-cycle strobe. The strobe is also driven out for the time counter. When the committed prescaler-run bit is 0, the tick fires on every cycle, so commits follow the raw clock. Reads always return committed values, never the held one.

Top module: `rtcw_sync_port`

## Requirements
- R1: After reset the enable register (address 0) and the alarm register (address 1) read 0, the prescaler register (address 2) reads 1, the status register (address 3) reads 0, and `irq_o` is low.
- R2: A write to address 0, 1 or 2 while nothing is pending makes status bit 14 read 1 from the next cycle. The addressed register keeps returning its old value until the commit.
- R3: A held write commits at the clock edge where `slow_tick_o` is high. At that same edge status bit 14 drops to 0, status bit 15 is set, and the new value becomes readable.
- R4: A write to address 0, 1 or 2 that arrives while status bit 14 is 1 is discarded: the value later committed is the first one.
- R5: A write to address 3 clears, at the next edge, every stored status bit whose data bit is 1 and leaves bits written 0 unchanged. Bit 14 cannot be cleared this way.
- R6: A high level on `evt_i[k]` sets status bit k (k below 14) at the next edge, and the bit stays set after the input drops. A set and a clear in the same cycle leave the bit set.
- R7: `irq_o` is high exactly when some stored status bit (0 to 13, or 15) is 1 and the committed enable register has a 1 at the same bit position. Bit 14 never raises it.
- R8: While bit 0 of the committed prescaler register is 0, `slow_tick_o` is high every cycle, so a held write commits one edge after capture.
- R9: A write to address 3 never sets status bit 14.
- R10: With bit 0 of the prescaler register at 1, `slow_tick_o` pulses for one cycle every `DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | 2 | Write address: 0 enable, 1 alarm, 2 prescaler, 3 status |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address, same map |
| rd_data_o | output | DATA_W | Committed value at `rd_addr_i` (combinational) |
| evt_i | input | EVT_W | Event set inputs from the time counter |
| slow_tick_o | output | 1 | One-cycle slow tick strobe |
| alarm_o | output | DATA_W | Committed alarm value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench attacks the edge where a held write meets the tick. A design that commits one edge late, or that leaves the pending flag up for a cycle after the done flag rises, is caught by a sample taken just before and just after that edge. A second write issued while the first is held must not replace it. A design that queues or overwrites would commit the wrong value. Clearing the status register is checked with mixed 1 and 0 data bits, with a simultaneous event, and to confirm that such a write never starts a pending cycle. The raw-clock mode is checked by committing a write one edge after capture.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;

   typedef enum logic [1:0] {
      RA_IEN   = 2'd0,
      RA_ALARM = 2'd1,
      RA_PSC   = 2'd2,
      RA_STAT  = 2'd3
   } rtcw_addr_e;

   // status positions that software decodes
   localparam int unsigned PEND_BIT = 14;
   localparam int unsigned DONE_BIT = 15;

endpackage

// File: rtl/rtcw_tick_gen.sv
module rtcw_tick_gen #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic slow_en_i,
   output logic tick_o
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt_q;
   logic          at_end;

   initial begin : p_param_chk
      assert (DIV >= 2) else $error("rtcw_tick_gen: DIV must be at least 2");
   end

   assign at_end = (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt_q <= '0;
      else if (!slow_en_i || at_end)  cnt_q <= '0;
      else                            cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = slow_en_i ? at_end : 1'b1;

   // R10
   tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && slow_en_i) |=> (!tick_o || !slow_en_i));

endmodule

// File: rtl/rtcw_hold_stage.sv
module rtcw_hold_stage #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_fire_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              tick_i,
   output logic              pending_o,
   output logic              commit_o,
   output logic [ADDR_W-1:0] commit_addr_o,
   output logic [DATA_W-1:0] commit_data_o
);
   logic              pend_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   assign accept = wr_fire_i && !pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         pend_q <= 1'b1;
         addr_q <= wr_addr_i;
         data_q <= wr_data_i;
      end else if (pend_q && tick_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pending_o     = pend_q;
   assign commit_o      = pend_q && tick_i;
   assign commit_addr_o = addr_q;
   assign commit_data_o = data_q;

   // R2
   capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_fire_i && !pend_q) |=> (pend_q && data_q == $past(wr_data_i)));
   // R4
   drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_fire_i && pend_q && !tick_i) |=> (pend_q && $stable(data_q) && $stable(addr_q)));
   // R3
   commit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && tick_i) |=> !pend_q);

endmodule

// File: rtl/rtcw_status_reg.sv
module rtcw_status_reg
   import rtcw_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned EVT_W    = 14,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [EVT_W-1:0]  evt_i,
   input  logic              done_set_i,
   input  logic              pending_i,
   input  logic              clr_we_i,
   input  logic [DATA_W-1:0] clr_data_i,
   input  logic [DATA_W-1:0] ien_i,
   output logic [DATA_W-1:0] stat_o,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] PEND_MASK = DATA_W'(1) << PEND_BIT;

   logic [DATA_W-1:0] set_v;
   logic [DATA_W-1:0] clr_v;
   logic              unused_in;

   initial begin : p_param_chk
      assert (DATA_W >= 16) else $error("rtcw_status_reg: DATA_W below 16");
      assert (EVT_W >= 1 && EVT_W <= PEND_BIT) else $error("rtcw_status_reg: EVT_W out of range");
   end

   always_comb begin
      set_v              = '0;
      set_v[EVT_W-1:0]   = evt_i;
      set_v[DONE_BIT]    = done_set_i;
   end

   assign clr_v = clr_we_i ? clr_data_i : '0;

   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      if (k == PEND_BIT) begin : g_pend
         assign stat_o[k] = pending_i;
      end else if (k == DONE_BIT || k < EVT_W) begin : g_keep
         logic q;
         logic nxt;
         if (SET_WINS) begin : g_set_first
            assign nxt = set_v[k] | (q & ~clr_v[k]);
         end else begin : g_clr_first
            assign nxt = (q | set_v[k]) & ~clr_v[k];
         end
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q <= 1'b0;
            else         q <= nxt;
         end
         assign stat_o[k] = q;

         // R5
         w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_v[k] && !set_v[k]) |=> !stat_o[k]);
         // R6
         if (SET_WINS) begin : g_set_chk
            set_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
               set_v[k] |=> stat_o[k]);
         end
      end else begin : g_zero
         assign stat_o[k] = 1'b0;
      end
   end

   assign irq_o     = |(stat_o & ien_i & ~PEND_MASK);
   assign unused_in = ^{clr_data_i, ien_i};

endmodule

// File: rtl/rtcw_sync_port.sv
module rtcw_sync_port
   import rtcw_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned EVT_W    = 14,
   parameter int unsigned DIV      = 32768,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_valid_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [EVT_W-1:0]  evt_i,
   output logic              slow_tick_o,
   output logic [DATA_W-1:0] alarm_o,
   output logic              irq_o
);
   localparam int unsigned ADDR_W = 2;

   logic              to_stat;
   logic              sync_fire;
   logic              pending;
   logic              commit;
   logic [ADDR_W-1:0] commit_addr;
   logic [DATA_W-1:0] commit_data;
   logic [DATA_W-1:0] ien_q;
   logic [DATA_W-1:0] alarm_q;
   logic              psc_run_q;
   logic [DATA_W-1:0] stat;

   assign to_stat   = (rtcw_addr_e'(wr_addr_i) == RA_STAT);
   assign sync_fire = wr_valid_i && !to_stat;

   rtcw_tick_gen #(.DIV(DIV)) u_tick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .slow_en_i (psc_run_q),
      .tick_o    (slow_tick_o)
   );

   rtcw_hold_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_hold (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_fire_i     (sync_fire),
      .wr_addr_i     (wr_addr_i),
      .wr_data_i     (wr_data_i),
      .tick_i        (slow_tick_o),
      .pending_o     (pending),
      .commit_o      (commit),
      .commit_addr_o (commit_addr),
      .commit_data_o (commit_data)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ien_q     <= '0;
         alarm_q   <= '0;
         psc_run_q <= 1'b1;
      end else if (commit) begin
         unique case (rtcw_addr_e'(commit_addr))
            RA_IEN:   ien_q     <= commit_data;
            RA_ALARM: alarm_q   <= commit_data;
            RA_PSC:   psc_run_q <= commit_data[0];
            default:  ;
         endcase
      end
   end

   rtcw_status_reg #(.DATA_W(DATA_W), .EVT_W(EVT_W), .SET_WINS(SET_WINS)) u_stat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i),
      .done_set_i (commit),
      .pending_i  (pending),
      .clr_we_i   (wr_valid_i && to_stat),
      .clr_data_i (wr_data_i),
      .ien_i      (ien_q),
      .stat_o     (stat),
      .irq_o      (irq_o)
   );

   always_comb begin
      unique case (rtcw_addr_e'(rd_addr_i))
         RA_IEN:   rd_data_o = ien_q;
         RA_ALARM: rd_data_o = alarm_q;
         RA_PSC:   rd_data_o = {{(DATA_W-1){1'b0}}, psc_run_q};
         default:  rd_data_o = stat;
      endcase
   end

   assign alarm_o = alarm_q;

   // R9
   stat_write_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_i && to_stat && !pending) |=> !stat[PEND_BIT]);
   // R3
   done_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pending && slow_tick_o) |=> (stat[DONE_BIT] && !stat[PEND_BIT]));

endmodule

// File: tb/rtcw_sync_port_bench.sv
module rtcw_sync_port_bench;
   localparam int unsigned DW  = 16;
   localparam int unsigned EW  = 14;
   localparam int unsigned DIV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [EW-1:0] evt = '0;
   logic          tick;
   logic [DW-1:0] alarm;
   logic          irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rtcw_sync_port #(.DATA_W(DW), .EVT_W(EW), .DIV(DIV)) u_rtcw_sync_port (
      .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .evt_i(evt), .slow_tick_o(tick), .alarm_o(alarm), .irq_o(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // read at the current negedge (combinational read path)
   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   // drive one write for one cycle; returns at the negedge after the capture edge
   task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // returns at a negedge inside a tick cycle
   task automatic wait_tick();
      @(negedge clk);
      while (!tick) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      rd(2'd0, d); chk("R1 enable", d, 0);
      rd(2'd1, d); chk("R1 alarm", d, 0);
      rd(2'd2, d); chk("R1 prescaler", d, 1);
      rd(2'd3, d); chk("R1 status", d, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_hold_and_commit();
      logic [DW-1:0] d;
      wait_tick();
      bus_write(2'd1, 16'h1234);
      rd(2'd3, d); chk("R2 pending bit 14", d[14], 1);
      rd(2'd1, d); chk("R2 alarm still old", d, 0);
      bus_write(2'd1, 16'h5555);           // R4: dropped
      wait_tick();
      rd(2'd3, d); chk("R3 pending before edge", d[14], 1);
      rd(2'd1, d); chk("R3 alarm before edge", d, 0);
      @(negedge clk);
      rd(2'd1, d); chk("R4 first write kept", d, 16'h1234);
      chk("R3 alarm_o", alarm, 16'h1234);
      rd(2'd3, d); chk("R3 done set / pending clear", d[15:14], 2'b10);
   endtask

   task automatic t_tick_period();
      int gap = 0;
      wait_tick();
      @(negedge clk); gap = 1;
      while (!tick) begin @(negedge clk); gap++; end
      chk("R10 tick period", gap, DIV);
   endtask

   task automatic t_w1c();
      logic [DW-1:0] d;
      bus_write(2'd3, 16'h4001);
      rd(2'd3, d); chk("R5 bit15 kept when written 0", d[15], 1);
      chk("R9 no pending from status write", d[14], 0);
      bus_write(2'd3, 16'h8000);
      rd(2'd3, d); chk("R5 bit15 cleared", d, 0);
   endtask

   task automatic t_events();
      logic [DW-1:0] d;
      @(negedge clk); evt = 14'h0008;
      @(negedge clk); evt = '0;
      rd(2'd3, d); chk("R6 event sets bit 3", d, 16'h0008);
      @(negedge clk);
      rd(2'd3, d); chk("R6 bit 3 sticky", d, 16'h0008);
      @(negedge clk); evt = 14'h0020; wr_valid = 1'b1; wr_addr = 2'd3; wr_data = 16'h0020;
      @(negedge clk); evt = '0; wr_valid = 1'b0;
      rd(2'd3, d); chk("R6 set wins over clear", d, 16'h0028);
      bus_write(2'd3, 16'h0020);
      rd(2'd3, d); chk("R5 bit 5 cleared, bit 3 kept", d, 16'h0008);
   endtask

   task automatic t_irq();
      logic [DW-1:0] d;
      chk("R7 no irq while disabled", irq, 0);
      wait_tick();
      bus_write(2'd0, 16'h4008);
      chk("R7 no irq before enable commits", irq, 0);
      wait_tick();
      @(negedge clk);
      chk("R7 irq with bit 3 enabled", irq, 1);
      bus_write(2'd3, 16'h8008);
      rd(2'd3, d); chk("R5 status cleared", d, 0);
      chk("R7 irq drops after clear", irq, 0);
      wait_tick();
      bus_write(2'd0, 16'h0000);
      rd(2'd3, d);
      chk("R7 pending bit 14 raises no irq", {d[14], irq}, 2'b10);
      wait_tick();
      @(negedge clk);
      bus_write(2'd3, 16'hFFFF);
   endtask

   task automatic t_raw();
      logic [DW-1:0] d;
      wait_tick();
      bus_write(2'd2, 16'h0000);
      wait_tick();
      @(negedge clk);
      rd(2'd2, d); chk("R8 prescaler off", d, 0);
      chk("R8 tick every cycle a", tick, 1);
      @(negedge clk);
      chk("R8 tick every cycle b", tick, 1);
      bus_write(2'd1, 16'h00AA);
      rd(2'd1, d); chk("R8 not yet committed", d, 16'h1234);
      @(negedge clk);
      rd(2'd1, d); chk("R8 committed one edge later", d, 16'h00AA);
      bus_write(2'd2, 16'h0001);
      @(negedge clk);
      rd(2'd2, d); chk("R8 prescaler back on", d, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hold_and_commit();
      t_tick_period();
      bus_write(2'd3, 16'h0000);
      t_w1c();
      t_events();
      t_irq();
      t_raw();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule